// File: doc/BRIEF.md
# Table-Driven Branch Execution Unit

This unit executes the 32-bit table-branch instruction of a simple in-order core. The core hands it an instruction word, the instruction's address and a start strobe. The unit decodes the word and points the register file at two registers, a table base and an entry index. It then forms the address of a single table entry and reads that entry through a valid/ready memory request channel. The entry is a byte or a halfword, chosen by one instruction bit, and the address may be unaligned.

When the response arrives, the entry is zero-extended and doubled, then added to the instruction address plus 4. That sum becomes a forward branch target, presented together with a one-cycle redirect strobe. A condition-pass input stops the read and the redirect when the condition fails.

A set of conditions marks the use of the instruction as unpredictable: using the program counter as the index, wrong values in the bits that should hold fixed values, or use inside a conditional-execution block in any position other than the last. These conditions raise a flag but do not stop execution. Register writeback and condition evaluation are handled elsewhere in the core.

Top module: `tbranch_unit`

## Requirements
- R1: A start is accepted only when the word matches: bits 31:25 = 1110100, bits 24:21 = 0110, bit 20 = 1 and bits 7:5 = 000. A non-matching word is ignored: no request, no redirect, and busy stays low. base_sel_o shows bits 19:16 and index_sel_o shows bits 3:0 of insn_i.
- R2: With bit 4 = 0 (byte entries), the request address is base + index, mreq_half_o is 0, and only bits 7:0 of the response are used.
- R3: With bit 4 = 1 (halfword entries), the request address is base + (index << 1), mreq_half_o is 1, and the address may be odd.
- R4: The target is (insn_pc_i + 4) + 2 × the zero-extended entry, so it always lies ahead of insn_pc_i + 4.
- R5: When the base register number is 15, insn_pc_i + 4 is used as the base in place of base_val_i.
- R6: An index register number of 15 sets unpred_o.
- R7: If bits 15:12 are not 1111 or bits 11:8 are not 0000, unpred_o is set, and the instruction still executes normally.
- R8: If in_cblk_i is 1 and cblk_last_i is 0, unpred_o is set. Use in the last position of a block, or outside any block, does not set it by this rule.
- R9: If cond_pass_i is 0 when a matching start is accepted, no memory request is made and no redirect follows.
- R10: The request stays valid, with a stable address and size, until mreq_ready_i is seen. After that, exactly one response is taken.
- R11: redirect_o is high for exactly one cycle, and target_o bit 0 is 0 while it is high. The unit is idle (busy_o low) in the cycle after.
- R12: After reset, busy_o, mreq_valid_o, redirect_o and unpred_o are all 0. unpred_o is updated at each accepted matching start and then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Instruction presented for execution |
| insn_i | input | 32 | Instruction word |
| insn_pc_i | input | AW | Instruction address |
| cond_pass_i | input | 1 | Condition for this instruction passed |
| in_cblk_i | input | 1 | Instruction lies inside a conditional-execution block |
| cblk_last_i | input | 1 | Instruction is the last of that block |
| base_sel_o | output | 4 | Register-file read select for the base |
| index_sel_o | output | 4 | Register-file read select for the index |
| base_val_i | input | AW | Base register value |
| index_val_i | input | AW | Index register value |
| mreq_valid_o | output | 1 | Memory read request valid |
| mreq_ready_i | input | 1 | Memory accepts the request |
| mreq_addr_o | output | AW | Table-entry byte address |
| mreq_half_o | output | 1 | 1 = halfword read, 0 = byte read |
| mrsp_valid_i | input | 1 | Read data valid |
| mrsp_data_i | input | EW | Read data, entry in the low bits |
| busy_o | output | 1 | Unit is executing an instruction |
| redirect_o | output | 1 | One-cycle branch redirect strobe |
| target_o | output | AW | Branch target address |
| unpred_o | output | 1 | Last accepted instruction was unpredictable |

## Verification
The assertions assume three things about the inputs. Memory returns a response only after it has accepted a request. The sum of the instruction address, 4 and the doubled entry does not wrap the address space. Register values are sampled only in the start cycle. The stimulus keeps to all three: it uses small instruction and table addresses, and its memory model raises response-valid only in a cycle after the request handshake. Ready is held off for 0 to 2 cycles so that the hold of the request is exercised, and byte responses carry garbage in the upper bits.

// File: rtl/tbranch_pkg.sv
package tbranch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REDIR = 2'd3
  } tb_state_e;

  typedef struct packed {
    logic       hit;
    logic       half;
    logic [3:0] rn;
    logic [3:0] rm;
    logic       sbz_bad;
  } dec_t;

  localparam logic [3:0] PC_REG = 4'd15;
endpackage

// File: rtl/tbranch_decode.sv
module tbranch_decode
  import tbranch_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.hit     = (insn_i[31:25] == 7'b1110100) && (insn_i[24:21] == 4'b0110)
                 && insn_i[20] && (insn_i[7:5] == 3'b000);
    dec_o.rn      = insn_i[19:16];
    dec_o.rm      = insn_i[3:0];
    dec_o.half    = insn_i[4];
    dec_o.sbz_bad = (insn_i[15:12] != 4'hF) || (insn_i[11:8] != 4'h0);
  end
endmodule

// File: rtl/tbranch_agen.sv
module tbranch_agen
  import tbranch_pkg::*;
#(
  parameter int AW = 32
) (
  input  dec_t          dec_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [AW-1:0] index_val_i,
  output logic [AW-1:0] pc4_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_eff;
  logic [AW-1:0] offset;

  always_comb begin
    pc4_o    = pc_i + AW'(4);
    base_eff = (dec_i.rn == PC_REG) ? pc4_o : base_val_i;
    offset   = dec_i.half ? {index_val_i[AW-2:0], 1'b0} : index_val_i;
    addr_o   = base_eff + offset;
  end
endmodule

// File: rtl/tbranch_ctrl.sv
module tbranch_ctrl
  import tbranch_pkg::*;
#(
  parameter int AW = 32,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          cond_pass_i,
  input  logic          in_cblk_i,
  input  logic          cblk_last_i,
  input  dec_t          dec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] pc4_i,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic [AW-1:0] mreq_addr_o,
  output logic          mreq_half_o,
  input  logic          mrsp_valid_i,
  input  logic [EW-1:0] mrsp_data_i,
  output logic          busy_o,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          unpred_o
);
  localparam int BW = EW / 2;

  tb_state_e     state_q;
  logic [AW-1:0] addr_q, pc4_q, target_q;
  logic          half_q, unpred_q;
  logic          take;
  logic [EW-1:0] entry;
  logic [AW-1:0] tgt_sum;

  assign take = (state_q == ST_IDLE) && start_i && dec_i.hit;

  always_comb begin
    entry   = half_q ? mrsp_data_i : {{(EW-BW){1'b0}}, mrsp_data_i[BW-1:0]};
    tgt_sum = pc4_q + (AW'(entry) << 1);
    tgt_sum[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      pc4_q    <= '0;
      target_q <= '0;
      half_q   <= 1'b0;
      unpred_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          unpred_q <= dec_i.sbz_bad || (dec_i.rm == PC_REG) || (in_cblk_i && !cblk_last_i);
          addr_q   <= addr_i;
          half_q   <= dec_i.half;
          pc4_q    <= pc4_i;
          if (cond_pass_i) state_q <= ST_REQ;
        end
        ST_REQ:  if (mreq_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mrsp_valid_i) begin
          target_q <= tgt_sum;
          state_q  <= ST_REDIR;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mreq_valid_o = (state_q == ST_REQ);
  assign mreq_addr_o  = addr_q;
  assign mreq_half_o  = half_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign redirect_o   = (state_q == ST_REDIR);
  assign target_o     = target_q;
  assign unpred_o     = unpred_q;

  // R10: request held with stable address and size until accepted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_half_o)));

  // R11: redirect is a single-cycle pulse followed by idle
  assert_redirect_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> (!redirect_o && !busy_o));

  // R11: target halfword aligned when presented
  assert_target_even_R11: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (target_o[0] == 1'b0));

  // R4: branch is forward of the PC value
  assert_forward_R4: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (target_o >= pc4_q));

  // R9: a failed condition leaves the unit idle
  assert_cond_fail_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && start_i && !cond_pass_i) |=> !busy_o);

  // R10: request and redirect never together
  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mreq_valid_o, redirect_o}));

  // R12: unpredictable flag changes only when a start is taken
  assert_unpred_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(unpred_o));
endmodule

// File: rtl/tbranch_unit.sv
module tbranch_unit
  import tbranch_pkg::*;
#(
  parameter int AW = 32,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [31:0]   insn_i,
  input  logic [AW-1:0] insn_pc_i,
  input  logic          cond_pass_i,
  input  logic          in_cblk_i,
  input  logic          cblk_last_i,
  output logic [3:0]    base_sel_o,
  output logic [3:0]    index_sel_o,
  input  logic [AW-1:0] base_val_i,
  input  logic [AW-1:0] index_val_i,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic [AW-1:0] mreq_addr_o,
  output logic          mreq_half_o,
  input  logic          mrsp_valid_i,
  input  logic [EW-1:0] mrsp_data_i,
  output logic          busy_o,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          unpred_o
);
  dec_t          dec;
  logic [AW-1:0] pc4, addr;

  tbranch_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  tbranch_agen #(.AW(AW)) u_agen (
    .dec_i       (dec),
    .pc_i        (insn_pc_i),
    .base_val_i  (base_val_i),
    .index_val_i (index_val_i),
    .pc4_o       (pc4),
    .addr_o      (addr)
  );

  tbranch_ctrl #(.AW(AW), .EW(EW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cond_pass_i  (cond_pass_i),
    .in_cblk_i    (in_cblk_i),
    .cblk_last_i  (cblk_last_i),
    .dec_i        (dec),
    .addr_i       (addr),
    .pc4_i        (pc4),
    .mreq_valid_o (mreq_valid_o),
    .mreq_ready_i (mreq_ready_i),
    .mreq_addr_o  (mreq_addr_o),
    .mreq_half_o  (mreq_half_o),
    .mrsp_valid_i (mrsp_valid_i),
    .mrsp_data_i  (mrsp_data_i),
    .busy_o       (busy_o),
    .redirect_o   (redirect_o),
    .target_o     (target_o),
    .unpred_o     (unpred_o)
  );

  assign base_sel_o  = dec.rn;
  assign index_sel_o = dec.rm;

  // R1: a non-matching start leaves the unit idle
  assert_nomatch_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !dec.hit) |=> !busy_o);
endmodule

// File: tb/tbranch_unit_tb_top.sv
module tbranch_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [AW-1:0] insn_pc_i = '0, base_val_i = '0, index_val_i = '0;
  logic cond_pass_i = 1'b0, in_cblk_i = 1'b0, cblk_last_i = 1'b0;
  logic [3:0] base_sel_o, index_sel_o;
  logic mreq_valid_o, mreq_ready_i = 1'b0, mreq_half_o;
  logic [AW-1:0] mreq_addr_o, target_o;
  logic mrsp_valid_i = 1'b0;
  logic [EW-1:0] mrsp_data_i = '0;
  logic busy_o, redirect_o, unpred_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_addr_q[$];
  logic          exp_half_q[$];
  logic [AW-1:0] exp_tgt_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbranch_unit #(.AW(AW), .EW(EW)) dut_i (.*);

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], a[15:12]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input bit h, input logic [3:0] rn, input logic [3:0] rm, input bit sbz_ok);
    return {7'b1110100, 4'b0110, 1'b1, rn, (sbz_ok ? 8'hF0 : 8'h3C), 3'b000, h, rm};
  endfunction

  // Driver: presents one instruction and pushes expected items
  task automatic run_insn(input logic [31:0] w, input logic [AW-1:0] pc, input logic [AW-1:0] bv,
                          input logic [AW-1:0] iv, input bit cond, input bit inb, input bit last,
                          input bit exp_unp, input string tag);
    logic [AW-1:0] base, addr, tgt;
    logic [15:0] ent;
    bit hit;
    hit  = (w[31:25] == 7'b1110100) && (w[24:21] == 4'b0110) && w[20] && (w[7:5] == 3'b000);
    base = (w[19:16] == 4'd15) ? pc + 4 : bv;
    addr = base + (w[4] ? (iv << 1) : iv);
    ent  = w[4] ? {mem_byte(addr + 1), mem_byte(addr)} : {8'h00, mem_byte(addr)};
    tgt  = pc + 4 + {ent, 1'b0};
    if (hit && cond) begin
      exp_addr_q.push_back(addr);
      exp_half_q.push_back(w[4]);
      exp_tgt_q.push_back(tgt);
    end
    @(negedge clk);
    insn_i = w; insn_pc_i = pc; base_val_i = bv; index_val_i = iv;
    cond_pass_i = cond; in_cblk_i = inb; cblk_last_i = last; start_i = 1'b1;
    #1;
    check(base_sel_o == w[19:16], {"R1 base select ", tag}, AW'(base_sel_o), AW'(w[19:16]));
    check(index_sel_o == w[3:0], {"R1 index select ", tag}, AW'(index_sel_o), AW'(w[3:0]));
    @(negedge clk);
    start_i = 1'b0;
    insn_i = '0; base_val_i = 32'hDEAD_BEEF; index_val_i = 32'h0BAD_0BAD;
    if (hit) check(unpred_o == exp_unp, {"R6/R7/R8 unpredictable flag ", tag}, AW'(unpred_o), AW'(exp_unp));
    if (!(hit && cond)) begin
      for (int i = 0; i < 4; i++) begin
        check(!busy_o && !mreq_valid_o && !redirect_o, {"R1/R9 stays idle ", tag},
              AW'({busy_o, mreq_valid_o, redirect_o}), 0);
        @(negedge clk);
      end
    end else begin
      while (busy_o) @(negedge clk);
    end
  endtask

  // Memory responder
  initial begin : responder
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mreq_valid_o) begin
        logic [AW-1:0] a, ea;
        logic h, eh;
        a = mreq_addr_o; h = mreq_half_o;
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R9 unexpected request", a, 0);
        end else begin
          ea = exp_addr_q.pop_front(); eh = exp_half_q.pop_front();
          check(a == ea, h ? "R3 halfword address" : "R2 byte address", a, ea);
          check(h == eh, "R2/R3 size", AW'(h), AW'(eh));
        end
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          check(mreq_valid_o && mreq_addr_o == a && mreq_half_o == h, "R10 request held", mreq_addr_o, a);
        end
        dly = (dly + 1) % 3;
        mreq_ready_i = 1'b1;
        @(negedge clk);
        mreq_ready_i = 1'b0;
        mrsp_data_i = h ? {mem_byte(a + 1), mem_byte(a)} : {8'hA5, mem_byte(a)};
        mrsp_valid_i = 1'b1;
        @(negedge clk);
        mrsp_valid_i = 1'b0;
        mrsp_data_i = 16'hFFFF;
      end
    end
  end

  // Monitor: compares redirects against the scoreboard
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (redirect_o) begin
        if (exp_tgt_q.size() == 0) check(1'b0, "R9 unexpected redirect", target_o, 0);
        else begin
          logic [AW-1:0] et;
          et = exp_tgt_q.pop_front();
          check(target_o == et, "R4 target", target_o, et);
          check(target_o[0] == 1'b0, "R11 target aligned", AW'(target_o[0]), 0);
        end
        @(negedge clk);
        check(!redirect_o && !busy_o, "R11 single pulse then idle", AW'({redirect_o, busy_o}), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !mreq_valid_o && !redirect_o && !unpred_o, "R12 reset state",
          AW'({busy_o, mreq_valid_o, redirect_o, unpred_o}), 0);
    // byte entries
    run_insn(mk_insn(0, 4'd2, 4'd3, 1), 32'h200, 32'h1000, 32'd5, 1, 0, 0, 0, "R2 byte");
    // halfword entries, odd address
    run_insn(mk_insn(1, 4'd4, 4'd6, 1), 32'h300, 32'h2001, 32'd7, 1, 0, 0, 0, "R3 half odd");
    // base is the PC
    run_insn(mk_insn(0, 4'd15, 4'd1, 1), 32'h400, 32'h9999, 32'd3, 1, 0, 0, 0, "R5 pc base byte");
    run_insn(mk_insn(1, 4'd15, 4'd1, 1), 32'h402, 32'h9999, 32'd2, 1, 0, 0, 0, "R5 pc base half");
    // index register 15
    run_insn(mk_insn(0, 4'd2, 4'd15, 1), 32'h500, 32'h1800, 32'd9, 1, 0, 0, 1, "R6 index pc");
    // should-be bits wrong, still runs
    run_insn(mk_insn(1, 4'd2, 4'd3, 0), 32'h600, 32'h1A00, 32'd4, 1, 0, 0, 1, "R7 sbz");
    // conditional block positions
    run_insn(mk_insn(0, 4'd2, 4'd3, 1), 32'h700, 32'h1B00, 32'd1, 1, 1, 0, 1, "R8 not last");
    run_insn(mk_insn(0, 4'd2, 4'd3, 1), 32'h704, 32'h1B00, 32'd2, 1, 1, 1, 0, "R8 last");
    // condition fails
    run_insn(mk_insn(1, 4'd2, 4'd3, 1), 32'h800, 32'h1C00, 32'd2, 0, 0, 0, 0, "R9 cond fail");
    // non-matching words, unpred must keep prior value (0)
    run_insn(mk_insn(0, 4'd2, 4'd15, 1) & ~32'h0010_0000, 32'h900, 32'h1D00, 32'd2, 1, 0, 0, 0, "R1 bit20");
    run_insn(mk_insn(0, 4'd2, 4'd15, 1) | 32'h0000_0020, 32'h904, 32'h1D00, 32'd2, 1, 0, 0, 0, "R1 bits7:5");
    check(unpred_o == 1'b0, "R12 unpred held over ignored words", AW'(unpred_o), 0);
    // sweep
    for (int k = 0; k < 24; k++) begin
      run_insn(mk_insn(k[0], (k % 5 == 0) ? 4'd15 : 4'(k % 8), 4'(k % 7), 1),
               32'h1000 + 32'(k * 8), 32'h3000 + 32'(k * 37), 32'(k * 13 + 1), 1, 0, 0, 0, "R4 sweep");
    end
    repeat (5) @(negedge clk);
    check(exp_tgt_q.size() == 0 && exp_addr_q.size() == 0, "R10 all responses consumed",
          AW'(exp_tgt_q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule